// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an asynchronous 256K-word by 4-bit static RAM. The host offers one access at a time over a valid/ready request port that carries a write flag, an 18-bit word address and a 4-bit write value. The controller latches the request and plays out a strobe sequence on the RAM pins: an active-low chip select, an active-low write strobe and an active-low output enable. It also drives an address bus and the pad-side controls of a 4-bit tri-state data bus: a value to drive, a drive enable, and the value sampled from the pins. A read finishes with the sampled nibble in a result register and a one-cycle completion pulse.

Every RAM timing limit is a parameter in nanoseconds. At elaboration each one is turned into a whole number of clock cycles, rounding up against the clock-period parameter, and no phase is shorter than one cycle. Writes are controlled by the write strobe. Output enable stays low for the whole of any access, so the write sequence first waits for the RAM to release the bus and only then drives data. The data phase is stretched until the data-setup, write-pulse and address-to-write-end limits all hold. A closing phase keeps the chip selected with the address unchanged until the write-cycle minimum is met.

Back-pressure rules: a request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after that edge until the closing phase has finished. The host may change or drop `req_addr`, `req_wdata` and `req_write` as soon as the request is taken. Nothing on the host side stalls the completion pulse.

Top module: `sram_ctl`

## Requirements
- R1: During and right after reset, chip select, write strobe and output enable are high, the data-bus drive enable is low, `req_ready` is high and `rsp_done` is low.
- R2: A request is taken on an edge where `req_valid` and `req_ready` are high. `req_ready` is then low until the access ends. `sram_addr` holds the taken address for the whole access, and later changes on the request inputs have no effect on it. With `req_valid` low, the RAM stays deselected.
- R3: Each phase lasts max(1, ceil(t_ns / CLK_NS)) cycles for its governing limit. With the bench settings this gives setup 1, release 2, data 3, closing 2 and read 3 cycles.
- R4: A write runs setup (chip selected, write strobe high), then write strobe low for release plus data cycles, then closing (chip selected, write strobe high). The write strobe is low only while the chip is selected.
- R5: The data bus is driven only while the write strobe is low and only after the release cycles have passed. The drive stops on the same edge that raises the write strobe, so the RAM and the controller never drive the bus together.
- R6: While the bus is driven, `sram_dq_o` carries the write value taken with the request, and that value is what the RAM stores.
- R7: A read holds chip select and output enable low and the write strobe high for the read cycle count, and never drives the bus.
- R8: On the last read cycle the value on `sram_dq_i` is captured into `rsp_rdata`. `rsp_done` is high for exactly the one cycle after capture, and `rsp_rdata` holds its value until the next capture.
- R9: Output enable is low only while the chip is selected, and the chip is deselected for at least one cycle between accesses.
- R10: `rsp_done` never pulses for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Controller idle, able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 4 | Write value |
| rsp_done | output | 1 | One-cycle pulse: read value available |
| rsp_rdata | output | 4 | Last value read |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_addr | output | 18 | RAM address bus |
| sram_dq_o | output | 4 | Value for the tri-state data pads |
| sram_dq_oe | output | 1 | Drive enable for the data pads |
| sram_dq_i | input | 4 | Value sampled from the data pads |

## Verification
Every strobe is a register that changes on the same edge as the state, so the first RAM-side cycle of an access is the one right after the accepting edge. The result appears, together with `req_ready` rising, in the cycle after the last timed phase. The bench drives on falling edges and samples on falling edges, so every cycle of an access is seen once. It counts the cycles of each phase between acceptance and the return of `req_ready` and compares those counts with values worked out from the rounding rule. It checks the completion pulse and the read value in the first cycle with `req_ready` high and again one cycle later, where the pulse must be gone and the value kept.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_W_SU  = 3'd1,
    ST_W_REL = 3'd2,
    ST_W_DRV = 3'd3,
    ST_W_END = 3'd4,
    ST_R_WAIT = 3'd5
  } ctl_state_e;

  // whole cycles covering ns nanoseconds, never fewer than one
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // a - b, floored at one cycle
  function automatic int unsigned rest_min1(input int unsigned a, input int unsigned b);
    return (a > b) ? (a - b) : 1;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic         last
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (ld) begin
      cnt_q <= ld_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == '0);

  // counter parks at zero until reloaded, so a phase never wraps around
  AST_TMR_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) == '0 && !$past(ld)) |-> (cnt_q == '0)); // R3

endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] pad_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= pad_in;
    end
  end

  // the accept and capture strobes come from the sequencer: never together
  AST_ACC_CAP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && capture)); // R8

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int unsigned SU_CYC  = 1,
  parameter int unsigned REL_CYC = 1,
  parameter int unsigned DAT_CYC = 1,
  parameter int unsigned END_CYC = 1,
  parameter int unsigned RD_CYC  = 2,
  parameter int unsigned CNT_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_last,
  output logic             tmr_ld,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             ready,
  output logic             done,
  output logic             ce_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe
);

  localparam logic [CNT_W-1:0] SU_LD  = CNT_W'(SU_CYC - 1);
  localparam logic [CNT_W-1:0] REL_LD = CNT_W'(REL_CYC - 1);
  localparam logic [CNT_W-1:0] DAT_LD = CNT_W'(DAT_CYC - 1);
  localparam logic [CNT_W-1:0] END_LD = CNT_W'(END_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);

  ctl_state_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    accept  = 1'b0;
    capture = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          tmr_ld = 1'b1;
          if (req_write) begin
            st_d    = ST_W_SU;
            tmr_val = SU_LD;
          end else begin
            st_d    = ST_R_WAIT;
            tmr_val = RD_LD;
          end
        end
      end
      ST_W_SU: begin
        if (tmr_last) begin
          st_d    = ST_W_REL;
          tmr_ld  = 1'b1;
          tmr_val = REL_LD;
        end
      end
      ST_W_REL: begin
        if (tmr_last) begin
          st_d    = ST_W_DRV;
          tmr_ld  = 1'b1;
          tmr_val = DAT_LD;
        end
      end
      ST_W_DRV: begin
        if (tmr_last) begin
          st_d    = ST_W_END;
          tmr_ld  = 1'b1;
          tmr_val = END_LD;
        end
      end
      ST_W_END: begin
        if (tmr_last) st_d = ST_IDLE;
      end
      ST_R_WAIT: begin
        if (tmr_last) begin
          capture = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // pin levels registered from the next state so each strobe is a clean flop
  logic ce_n_d, we_n_d, oe_n_d, dq_oe_d, ready_d;

  always_comb begin
    ce_n_d  = (st_d == ST_IDLE);
    oe_n_d  = (st_d == ST_IDLE);
    we_n_d  = !((st_d == ST_W_REL) || (st_d == ST_W_DRV));
    dq_oe_d = (st_d == ST_W_DRV);
    ready_d = (st_d == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ce_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
      ready <= 1'b1;
      done  <= 1'b0;
    end else begin
      st_q  <= st_d;
      ce_n  <= ce_n_d;
      we_n  <= we_n_d;
      oe_n  <= oe_n_d;
      dq_oe <= dq_oe_d;
      ready <= ready_d;
      done  <= capture;
    end
  end

  AST_WE_IN_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n); // R4
  AST_DRV_UNDER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !we_n); // R5
  AST_DRV_AFTER_REL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(!we_n)); // R5
  AST_OE_IN_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !ce_n); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_NOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(we_n)); // R10

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned DATA_W    = 4,
  parameter int unsigned CLK_NS    = 10,
  parameter int unsigned T_SA_NS   = 0,
  parameter int unsigned T_AW_NS   = 10,
  parameter int unsigned T_WP_NS   = 10,
  parameter int unsigned T_REL_NS  = 6,
  parameter int unsigned T_SD_NS   = 7,
  parameter int unsigned T_HA_NS   = 0,
  parameter int unsigned T_WC_NS   = 12,
  parameter int unsigned T_AA_NS   = 12,
  parameter int unsigned T_DOE_NS  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int unsigned SU_CYC  = ns_to_cyc(T_SA_NS, CLK_NS);
  localparam int unsigned REL_CYC = ns_to_cyc(T_REL_NS, CLK_NS);
  localparam int unsigned WP_CYC  = ns_to_cyc(T_WP_NS, CLK_NS);
  localparam int unsigned AW_CYC  = ns_to_cyc(T_AW_NS, CLK_NS);
  localparam int unsigned SD_CYC  = ns_to_cyc(T_SD_NS, CLK_NS);
  localparam int unsigned WC_CYC  = ns_to_cyc(T_WC_NS, CLK_NS);
  // data phase: setup before the rising strobe, full pulse width, address-to-end
  localparam int unsigned DAT_CYC = umax(SD_CYC, umax(rest_min1(WP_CYC, REL_CYC),
                                         rest_min1(AW_CYC, SU_CYC + REL_CYC)));
  localparam int unsigned BODY_CYC = SU_CYC + REL_CYC + DAT_CYC;
  localparam int unsigned END_CYC = umax(ns_to_cyc(T_HA_NS, CLK_NS), rest_min1(WC_CYC, BODY_CYC));
  localparam int unsigned RD_CYC  = umax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_DOE_NS, CLK_NS));
  localparam int unsigned MAX_CYC = umax(umax(SU_CYC, REL_CYC), umax(umax(DAT_CYC, END_CYC), RD_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic             tmr_ld;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_last;
  logic             accept;
  logic             capture;

  sram_ctl_fsm #(
    .SU_CYC (SU_CYC),
    .REL_CYC(REL_CYC),
    .DAT_CYC(DAT_CYC),
    .END_CYC(END_CYC),
    .RD_CYC (RD_CYC),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .tmr_last (tmr_last),
    .tmr_ld   (tmr_ld),
    .tmr_val  (tmr_val),
    .accept   (accept),
    .capture  (capture),
    .ready    (req_ready),
    .done     (rsp_done),
    .ce_n     (sram_ce_n),
    .we_n     (sram_we_n),
    .oe_n     (sram_oe_n),
    .dq_oe    (sram_dq_oe)
  );

  sram_ctl_timer #(
    .W(CNT_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (tmr_ld),
    .ld_val(tmr_val),
    .last  (tmr_last)
  );

  sram_ctl_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .in_addr (req_addr),
    .in_wdata(req_wdata),
    .capture (capture),
    .pad_in  (sram_dq_i),
    .addr_q  (sram_addr),
    .wdata_q (sram_dq_o),
    .rdata_q (rsp_rdata)
  );

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(sram_addr)); // R2
  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_o)); // R6
  AST_BUSY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !sram_ce_n); // R2
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_oe_n && sram_we_n) |-> !sram_dq_oe); // R7

endmodule

// File: tb/sram_ctl_tb_top.sv
module sram_ctl_tb_top;

  // bench timing: 100 MHz clock, limits chosen to make phases longer than one cycle
  localparam int CLK_NS = 10;
  // ceil(5/10)=1
  localparam int E_SU  = 1;
  // ceil(15/10)=2
  localparam int E_REL = 2;
  // max(ceil(7/10)=1, ceil(40/10)-2=2, ceil(60/10)-1-2=3)
  localparam int E_DAT = 3;
  // max(1, ceil(80/10)-(1+2+3)=2)
  localparam int E_END = 2;
  // max(ceil(25/10)=3, ceil(6/10)=1)
  localparam int E_RD  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        rsp_done;
  logic [3:0]  rsp_rdata;
  logic        sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [17:0] sram_addr;
  logic [3:0]  sram_dq_o;
  logic [3:0]  sram_dq_i = 'x;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_NS / 2) clk = ~clk;

  sram_ctl #(
    .CLK_NS  (CLK_NS),
    .T_SA_NS (5),
    .T_AW_NS (60),
    .T_WP_NS (40),
    .T_REL_NS(15),
    .T_SD_NS (7),
    .T_HA_NS (0),
    .T_WC_NS (80),
    .T_AA_NS (25),
    .T_DOE_NS(6)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata),
    .sram_ce_n (sram_ce_n),
    .sram_we_n (sram_we_n),
    .sram_oe_n (sram_oe_n),
    .sram_addr (sram_addr),
    .sram_dq_o (sram_dq_o),
    .sram_dq_oe(sram_dq_oe),
    .sram_dq_i (sram_dq_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // cycle-level RAM model, updated on falling edges
  logic [3:0] mem [int];
  int contention = 0;

  always @(negedge clk) begin
    if (!sram_ce_n && !sram_we_n && sram_dq_oe) mem[int'(sram_addr)] = sram_dq_o;
    if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
      sram_dq_i = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 4'h0;
      if (sram_dq_oe) contention++;
    end else begin
      sram_dq_i = 'x;
    end
  end

  function automatic logic [3:0] model_rd(input logic [17:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 4'h0;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(sram_ce_n === 1'b1 && sram_we_n === 1'b1 && sram_oe_n === 1'b1, "R1",
        "strobes high in reset", {sram_ce_n, sram_we_n, sram_oe_n}, 7);
    chk(sram_dq_oe === 1'b0 && rsp_done === 1'b0, "R1", "no drive, no done in reset",
        {sram_dq_oe, rsp_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && sram_ce_n === 1'b1, "R1", "ready after reset",
        {req_ready, sram_ce_n}, 3);
  endtask

  task automatic t_idle();
    int bad = 0;
    req_valid = 1'b0;
    req_write = 1'b1;
    req_addr  = 18'h2AAAA;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (sram_ce_n !== 1'b1 || sram_we_n !== 1'b1 || sram_oe_n !== 1'b1 ||
          req_ready !== 1'b1 || rsp_done !== 1'b0) bad++;
    end
    chk(bad == 0, "R2", "no access while valid low", bad, 0);
  endtask

  task automatic t_write(input logic [17:0] a, input logic [3:0] d);
    int su = 0, rel = 0, drv = 0, fin = 0, n = 0;
    int bad_addr = 0, bad_data = 0, bad_order = 0, bad_sel = 0, dones = 0;
    bit seen_we = 0;
    @(negedge clk);
    chk(req_ready === 1'b1, "R2", "ready before write", req_ready, 1);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_write = 1'b0;
    while (req_ready !== 1'b1 && n < 100) begin
      if (sram_ce_n !== 1'b0 || sram_oe_n !== 1'b0) bad_sel++;
      if (sram_addr !== a) bad_addr++;
      if (rsp_done === 1'b1) dones++;
      if (sram_we_n === 1'b0) begin
        seen_we = 1;
        if (sram_dq_oe === 1'b1) begin
          drv++;
          if (sram_dq_o !== d) bad_data++;
        end else begin
          rel++;
          if (drv > 0) bad_order++;
        end
      end else begin
        if (sram_dq_oe !== 1'b0) bad_order++;
        if (!seen_we) su++; else fin++;
      end
      n++;
      @(negedge clk);
    end
    chk(su == E_SU, "R3", "write setup cycles", su, E_SU);
    chk(rel == E_REL, "R5", "release cycles before drive", rel, E_REL);
    chk(drv == E_DAT, "R4", "data drive cycles", drv, E_DAT);
    chk(fin == E_END, "R4", "closing cycles", fin, E_END);
    chk(bad_order == 0, "R5", "drive only under low strobe, released at its rise", bad_order, 0);
    chk(bad_sel == 0, "R9", "chip and output enable selected through write", bad_sel, 0);
    chk(bad_addr == 0, "R2", "address held despite input change", bad_addr, 0);
    chk(bad_data == 0, "R6", "driven value equals taken value", bad_data, 0);
    chk(dones == 0 && rsp_done === 1'b0, "R10", "no done for write", dones, 0);
    chk(sram_ce_n === 1'b1, "R9", "deselected after write", sram_ce_n, 1);
    chk(model_rd(a) === d, "R6", "stored value", model_rd(a), d);
  endtask

  task automatic t_read(input logic [17:0] a);
    int rd = 0, n = 0, bad = 0;
    logic [3:0] exp;
    exp = model_rd(a);
    @(negedge clk);
    chk(req_ready === 1'b1, "R2", "ready before read", req_ready, 1);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 4'h0;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_write = 1'b1;
    while (req_ready !== 1'b1 && n < 100) begin
      if (sram_ce_n !== 1'b0 || sram_oe_n !== 1'b0 || sram_we_n !== 1'b1 ||
          sram_dq_oe !== 1'b0 || sram_addr !== a || rsp_done !== 1'b0) bad++;
      rd++;
      n++;
      @(negedge clk);
    end
    chk(rd == E_RD, "R7", "read strobe cycles", rd, E_RD);
    chk(bad == 0, "R7", "read strobe levels, no drive", bad, 0);
    chk(rsp_done === 1'b1, "R8", "done with ready", rsp_done, 1);
    chk(rsp_rdata === exp, "R8", "read value", rsp_rdata, exp);
    chk(sram_ce_n === 1'b1, "R9", "deselected after read", sram_ce_n, 1);
    @(negedge clk);
    chk(rsp_done === 1'b0, "R8", "done lasts one cycle", rsp_done, 0);
    chk(rsp_rdata === exp, "R8", "read value held", rsp_rdata, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    t_reset();
    t_idle();
    t_read(18'h00100);               // unwritten location reads the model default
    t_write(18'h00000, 4'h5);
    t_write(18'h3FFFF, 4'hA);
    t_write(18'h12345, 4'hF);
    t_read(18'h00000);
    t_read(18'h3FFFF);
    t_read(18'h12345);
    t_write(18'h12345, 4'h3);        // overwrite
    t_read(18'h12345);
    t_read(18'h3FFFF);
    chk(contention == 0, "R5", "no bus contention", contention, 0);
    finish_run();
  end

endmodule